// File: doc/BRIEF.md
# Programmable Clock Divider Tree

The block takes one master clock and derives three clock-enable streams from it: one for an ADC, one for a charge pump, and one driven out on a bidirectional clock pin. The master is either the internal oscillator clock or a clock arriving on that same pin. A single oscillator-enable input makes the choice. When it is 1, the oscillator is the master and the pin is driven as an output. When it is 0, the pin is an input and supplies the master.

All three channels count from one shared free-running counter, so their pulses always line up with each other. Each output is a one-cycle-wide enable pulse in the master domain. A divide-by-1 setting gives an enable that is held high. The ADC and charge-pump channels always see the undivided master, whatever the pin setting.

Each channel is a two-state machine. `ST_OFF` holds the output low. `ST_RUN` emits a pulse on every terminal count of its ratio. Three transitions are defined:
- OFF to RUN when the enable request appears. This transition is taken on the next edge.
- RUN to OFF when the request is withdrawn. This transition is taken at a terminal count.
- RUN to RUN with a reload of a new ratio at a terminal count.

Top module: `clock_divider_tree`

## Requirements
- R1: While reset is applied and on the first edge after it, `adc_ce` and `cp_ce` are low, `pin_oe` is high (with `osc_en`=1), and the pin channel starts running at divide-by-2; the ADC and charge-pump channels start off.
- R2: With `adc_en`=1, `adc_div` code k (0..3) selects divide by 2^k. On master edge t after reset (t=1,2,...), `adc_ce` is high when t mod 2^k = 0.
- R3: With `cp_en`=1, `cp_div` code k (0..3) selects divide by 2^(5+k), that is /32, /64, /128 or /256, with the same pulse timing rule as R2.
- R4: `pin_div` code 0 holds `pin_clk_out` low. Codes 1, 2 and 3 select /1, /2 and /4, with the same pulse timing rule as R2.
- R5: `pin_oe` equals `osc_en`. With `osc_en`=0 the pin channel is forced off, and `pin_clk_out` goes low no later than its next terminal count.
- R6: All channels share one counter. Whenever `cp_ce` pulses while the ADC channel is running, `adc_ce` pulses in the same cycle.
- R7: A new ratio or enable value for a running channel is adopted only at the edge where the current ratio reaches its terminal count. That edge still produces a pulse at the old ratio. A channel that is off adopts the request on the next edge.
- R8: Dropping `adc_en` or `cp_en` stops that channel at its next terminal count, and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| pin_clk_in | input | 1 | Clock received on the bidirectional pin |
| rst | input | 1 | Synchronous active-high reset, in the master domain |
| osc_en | input | 1 | 1: oscillator is the master and the pin is an output; 0: the pin is the master |
| adc_en | input | 1 | ADC channel enable request |
| adc_div | input | 2 | ADC ratio code (/1, /2, /4, /8) |
| cp_en | input | 1 | Charge-pump channel enable request |
| cp_div | input | 2 | Charge-pump ratio code (/32 to /256) |
| pin_div | input | 2 | Pin ratio code (off, /1, /2, /4) |
| adc_ce | output | 1 | ADC clock-enable pulse |
| cp_ce | output | 1 | Charge-pump clock-enable pulse |
| pin_clk_out | output | 1 | Clock-enable pulse for the pin driver |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions assume that the control inputs are stable around the master edge. They also assume that both clock sources run at the same rate, so switching `osc_en` causes no phase jump. The bench therefore drives every control input on the falling edge. It feeds one clock to both clock inputs, so the master is continuous across a source change. The "stays low" checks in the assertions allow a drain window of one full period at the largest ratio a channel can hold. The bench always waits longer than that window before it relies on the output being quiet.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } chan_state_e;

    localparam int NUM_CHAN = 3;
    localparam int CH_ADC   = 0;
    localparam int CH_CP    = 1;
    localparam int CH_PIN   = 2;
endpackage

// File: rtl/cdt_count.sv
module cdt_count #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/cdt_chan.sv
module cdt_chan
    import cdt_pkg::*;
#(
    parameter int CW      = 8,
    parameter int LW      = 4,
    parameter bit RST_ON  = 1'b0,
    parameter int RST_LOG = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          req_en,
    input  logic [LW-1:0] req_log,
    output logic          ce
);
    localparam chan_state_e RST_STATE = RST_ON ? ST_RUN : ST_OFF;

    chan_state_e   state_q, state_d;
    logic [LW-1:0] log_q, log_d;
    logic [CW:0]   one_sh;
    logic [CW-1:0] mask;
    logic          term;
    logic          ce_q;

    assign one_sh = (CW+1)'(1) << log_q;
    assign mask   = one_sh[CW-1:0] - CW'(1);
    assign term   = (cnt & mask) == mask;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RST_STATE;
            log_q   <= LW'(RST_LOG);
        end else begin
            state_q <= state_d;
            log_q   <= log_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        log_d   = log_q;
        unique case (state_q)
            ST_OFF: begin
                log_d   = req_log;
                state_d = req_en ? ST_RUN : ST_OFF;
            end
            ST_RUN: begin
                if (term) begin
                    log_d   = req_log;
                    state_d = req_en ? ST_RUN : ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) ce_q <= 1'b0;
        else     ce_q <= (state_q == ST_RUN) && term;
    end

    assign ce = ce_q;
endmodule

// File: rtl/clock_divider_tree.sv
module clock_divider_tree
    import cdt_pkg::*;
#(
    parameter int CW       = 8,
    parameter int ADC_BASE = 0,
    parameter int CP_BASE  = 5
) (
    input  logic       osc_clk,
    input  logic       pin_clk_in,
    input  logic       rst,
    input  logic       osc_en,
    input  logic       adc_en,
    input  logic [1:0] adc_div,
    input  logic       cp_en,
    input  logic [1:0] cp_div,
    input  logic [1:0] pin_div,
    output logic       adc_ce,
    output logic       cp_ce,
    output logic       pin_clk_out,
    output logic       pin_oe
);
    localparam int LW = $clog2(CW + 1);

    logic                mclk;
    logic [CW-1:0]       cnt;
    logic [NUM_CHAN-1:0] req_en;
    logic [LW-1:0]       req_log [NUM_CHAN];
    logic [NUM_CHAN-1:0] ce;

    assign mclk   = osc_en ? osc_clk : pin_clk_in;
    assign pin_oe = osc_en;

    assign req_en[CH_ADC]  = adc_en;
    assign req_log[CH_ADC] = LW'(ADC_BASE) + LW'(adc_div);
    assign req_en[CH_CP]   = cp_en;
    assign req_log[CH_CP]  = LW'(CP_BASE) + LW'(cp_div);
    assign req_en[CH_PIN]  = osc_en && (pin_div != 2'd0);
    assign req_log[CH_PIN] = (pin_div == 2'd0) ? '0 : LW'(pin_div) - LW'(1);

    cdt_count #(.CW(CW)) u_cnt (
        .clk (mclk),
        .rst (rst),
        .cnt (cnt)
    );

    for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
        cdt_chan #(
            .CW      (CW),
            .LW      (LW),
            .RST_ON  (i == CH_PIN),
            .RST_LOG ((i == CH_PIN) ? 1 : 0)
        ) u_chan (
            .clk     (mclk),
            .rst     (rst),
            .cnt     (cnt),
            .req_en  (req_en[i]),
            .req_log (req_log[i]),
            .ce      (ce[i])
        );
    end

    assign adc_ce      = ce[CH_ADC];
    assign cp_ce       = ce[CH_CP];
    assign pin_clk_out = ce[CH_PIN];
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cnt,
    input logic          osc_en,
    input logic          adc_en,
    input logic          adc_ce,
    input logic          cp_ce,
    input logic          pin_clk_out
);
    int adc_off_run;
    int pin_off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            adc_off_run <= 0;
            pin_off_run <= 0;
        end else begin
            adc_off_run <= adc_en ? 0 : ((adc_off_run < 1000) ? adc_off_run + 1 : adc_off_run);
            pin_off_run <= osc_en ? 0 : ((pin_off_run < 1000) ? pin_off_run + 1 : pin_off_run);
        end
    end

    AST_CP_PHASE: assert property (@(posedge clk) disable iff (rst)
        cp_ce |-> (cnt[4:0] == 5'd0)); // R3

    AST_CP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cp_ce |=> !cp_ce); // R3

    AST_ADC_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (adc_off_run >= 9) |-> !adc_ce); // R8

    AST_PIN_INPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pin_off_run >= 5) |-> !pin_clk_out); // R5
endmodule

bind clock_divider_tree cdt_checker #(.CW(CW)) u_chk (
    .clk         (mclk),
    .rst         (rst),
    .cnt         (cnt),
    .osc_en      (osc_en),
    .adc_en      (adc_en),
    .adc_ce      (adc_ce),
    .cp_ce       (cp_ce),
    .pin_clk_out (pin_clk_out)
);

// File: tb/clock_divider_tree_test.sv
module clock_divider_tree_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       osc_en;
    logic       adc_en;
    logic [1:0] adc_div;
    logic       cp_en;
    logic [1:0] cp_div;
    logic [1:0] pin_div;
    logic       adc_ce, cp_ce, pin_clk_out, pin_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int m_cnt;
    int m_on  [3];
    int m_lg  [3];
    int m_exp [3];
    int adc_was_on;

    always #4 clk = ~clk;

    clock_divider_tree uut (
        .osc_clk     (clk),
        .pin_clk_in  (clk),
        .rst         (rst),
        .osc_en      (osc_en),
        .adc_en      (adc_en),
        .adc_div     (adc_div),
        .cp_en       (cp_en),
        .cp_div      (cp_div),
        .pin_div     (pin_div),
        .adc_ce      (adc_ce),
        .cp_ce       (cp_ce),
        .pin_clk_out (pin_clk_out),
        .pin_oe      (pin_oe)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model: pulse rules from the requirements, evaluated per edge.
    always @(posedge clk) begin
        int rq_en, rq_lg, msk, term;
        cycles++;
        if (rst) begin
            m_cnt = 0;
            m_on  = '{0, 0, 1};
            m_lg  = '{0, 0, 1};
            m_exp = '{0, 0, 0};
            adc_was_on = 0;
        end else begin
            adc_was_on = m_on[0];
            for (int i = 0; i < 3; i++) begin
                if (i == 0) begin
                    rq_en = adc_en; rq_lg = int'(adc_div);
                end else if (i == 1) begin
                    rq_en = cp_en;  rq_lg = 5 + int'(cp_div);
                end else begin
                    rq_en = (osc_en && pin_div != 0) ? 1 : 0;
                    rq_lg = (pin_div == 0) ? 0 : int'(pin_div) - 1;
                end
                msk  = (1 << m_lg[i]) - 1;
                term = ((m_cnt & msk) == msk) ? 1 : 0;
                m_exp[i] = (m_on[i] != 0 && term != 0) ? 1 : 0;
                if (m_on[i] == 0 || term != 0) begin
                    m_on[i] = rq_en;
                    m_lg[i] = rq_lg;
                end
            end
            m_cnt = (m_cnt + 1) % 256;
        end
        #2;
        if (!done) begin
            if (rst) begin
                chk(int'(adc_ce), 0, "R1 adc_ce in reset");
                chk(int'(cp_ce), 0, "R1 cp_ce in reset");
                chk(int'(pin_oe), 1, "R1 pin_oe in reset");
            end else begin
                chk(int'(adc_ce), m_exp[0], "R2/R7/R8 adc_ce");
                chk(int'(cp_ce), m_exp[1], "R3/R7/R8 cp_ce");
                chk(int'(pin_clk_out), m_exp[2], "R4/R5 pin_clk_out");
                chk(int'(pin_oe), int'(osc_en), "R5 pin_oe");
                if (cp_ce && adc_was_on != 0)
                    chk(int'(adc_ce), 1, "R6 adc_ce aligned with cp_ce");
            end
        end
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired: actual %0d cycles expected below 150000", cycles);
            finish_run();
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; osc_en = 1'b1;
        adc_en = 1'b0; adc_div = 2'd0;
        cp_en = 1'b0;  cp_div = 2'd0;
        pin_div = 2'd2;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(20);                         // R1: pin at /2, others off
        adc_en = 1'b1;
        for (int d = 0; d < 4; d++) begin     // R2
            adc_div = 2'(d);
            wait_cyc(40);
        end
        adc_div = 2'd3; wait_cyc(11);         // R7: change mid-period
        adc_div = 2'd1; wait_cyc(20);
        cp_en = 1'b1;
        for (int d = 0; d < 4; d++) begin     // R3, R6
            cp_div = 2'(d);
            wait_cyc(600);
        end
        for (int p = 0; p < 4; p++) begin     // R4
            pin_div = 2'(p);
            wait_cyc(24);
        end
        osc_en = 1'b0; wait_cyc(30);          // R5
        osc_en = 1'b1; wait_cyc(20);
        adc_en = 1'b0; wait_cyc(30);          // R8
        cp_en = 1'b0;  wait_cyc(300);
        done = 1'b1;
        finish_run();
    end
endmodule